// File: doc/BRIEF.md
# Priority Pause Frame Transmit Generator

This block builds a priority-based flow control pause frame, as defined by IEEE 802.1Qbb, and places it into a byte-wide transmit stream. A software request pulse starts the process. The pulse counts only while the link runs in full duplex and the transmitter is enabled. A request that arrives outside those conditions is dropped.

The frame is made of these fields, in transmit order:
- the reserved multicast destination address;
- the station's own source address;
- the MAC control type;
- the priority pause opcode;
- a priority enable vector;
- one pause time for each priority.

The enable vector and the pause times come from a configuration word. The frame ends after the last pause time. The block does not add a checksum or any padding.

The normal frame path feeds through this block and is controlled by a grant. A pause frame never splits a normal frame. If the transmitter is idle, the pause frame goes out at once. If a normal frame is in progress, the pause frame waits for that frame's end marker and then goes out before the next normal frame starts. The grant stays low until the pause frame's end marker has left the block.

Top module: `pfc_tx_gen`

## Requirements
- R1: After reset, tx_valid_o is low and norm_gnt_o is high.
- R2: A request is taken only if full_duplex_i and tx_en_i are both high in the cycle in which req_i is sampled. Otherwise it is dropped and no frame is sent.
- R3: The frame is 34 bytes long, and each multibyte field is sent most significant byte first. The fields, in order, are:
  - bytes 0 to 5: 01 80 C2 00 00 01;
  - bytes 6 to 11: src_addr_i, starting with bits [47:40];
  - bytes 12 and 13: 88 08;
  - bytes 14 and 15: 01 01;
  - bytes 16 and 17: pev_i;
  - bytes 18 to 33: eight 16-bit pause times, priority 0 first. Priority i is taken from quanta_i[16i+15:16i].
- R4: The pause frame is sent with one byte per cycle and no gaps. tx_sof_o is high only on the first byte and tx_eof_o only on the last byte. Neither marker is ever high while tx_valid_o is low.
- R5: With no normal frame in progress, the first pause byte appears two cycles after the clock edge that samples the request.
- R6: If a normal frame is in progress, the pause frame starts only after that frame's end marker has been sent. A normal frame is never interrupted.
- R7: While a pause frame is pending in a gap or being sent, norm_gnt_o is low. Normal bytes offered during that time are held and not transmitted. The grant returns in the cycle after the pause end marker.
- R8: A request made while a pause frame is pending or being sent is merged into that frame. Only one frame results.
- R9: The source address, enable vector and pause times are captured when the frame starts. Later changes to those inputs do not affect that frame.
- R10: A pending request is withdrawn if full_duplex_i or tx_en_i goes low before the frame starts.
- R11: While norm_gnt_o is high, the normal path's data, valid, start and end signals appear unchanged on the output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Pause frame request pulse |
| full_duplex_i | input | 1 | Link operates in full duplex |
| tx_en_i | input | 1 | Transmitter enabled |
| src_addr_i | input | 48 | Station source address |
| pev_i | input | 16 | Priority enable vector |
| quanta_i | input | 128 | Pause times; priority i at [16i+15:16i] |
| norm_data_i | input | 8 | Normal path byte |
| norm_valid_i | input | 1 | Normal path byte valid |
| norm_sof_i | input | 1 | Normal path first byte of frame |
| norm_eof_i | input | 1 | Normal path last byte of frame |
| norm_gnt_o | output | 1 | Normal path may transmit |
| tx_data_o | output | 8 | Output byte |
| tx_valid_o | output | 1 | Output byte valid |
| tx_sof_o | output | 1 | Output first byte of frame |
| tx_eof_o | output | 1 | Output last byte of frame |

## Verification
The generator is tested with a request on an idle line, which checks the start latency and the contents of every byte. It is also tested with a request made partway through a normal frame that is followed back to back by a second normal frame. This shows that the pause frame goes into the gap and that the held frame resumes straight after the pause end marker.

Requests made in half duplex or with the transmitter disabled must produce no frame. So must a request that is withdrawn by a link change while it waits. This separates the check made when the request is accepted from the check made when the frame starts. Repeated requests, and configuration changes made after the start marker, show that requests merge into one frame and that the fields are captured at the start.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam logic [47:0] PFC_DST_ADDR = 48'h0180_C200_0001;
  localparam logic [15:0] PFC_ETYPE    = 16'h8808;
  localparam logic [15:0] PFC_OPCODE   = 16'h0101;
  localparam int          PFC_HDR_BYTES = 16;

  function automatic int frame_bytes(int pev_w, int num_prio, int quanta_w);
    return PFC_HDR_BYTES + pev_w / 8 + num_prio * quanta_w / 8;
  endfunction
endpackage

// File: rtl/pfc_frame_build.sv
module pfc_frame_build
  import pfc_pkg::*;
#(
  parameter int NUM_PRIO = 8,
  parameter int QUANTA_W = 16,
  parameter int PEV_W    = 16
) (
  input  logic [47:0]                  src_addr_i,
  input  logic [PEV_W-1:0]             pev_i,
  input  logic [NUM_PRIO*QUANTA_W-1:0] quanta_i,
  output logic [8*PFC_HDR_BYTES+PEV_W+NUM_PRIO*QUANTA_W-1:0] frame_o
);
  logic [NUM_PRIO*QUANTA_W-1:0] q_ord;

  // priority 0 lands in the most significant slot so it is sent first
  for (genvar g = 0; g < NUM_PRIO; g++) begin : g_ord
    assign q_ord[(NUM_PRIO-1-g)*QUANTA_W +: QUANTA_W] = quanta_i[g*QUANTA_W +: QUANTA_W];
  end

  assign frame_o = {PFC_DST_ADDR, src_addr_i, PFC_ETYPE, PFC_OPCODE, pev_i, q_ord};
endmodule

// File: rtl/pfc_gap_track.sv
module pfc_gap_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic sof_i,
  input  logic eof_i,
  output logic in_frame_o
);
  logic in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 in_frame_q <= 1'b0;
    else if (acc_i && eof_i)     in_frame_q <= 1'b0;
    else if (acc_i && sof_i)     in_frame_q <= 1'b1;
  end

  assign in_frame_o = in_frame_q;
endmodule

// File: rtl/pfc_tx_seq.sv
module pfc_tx_seq #(
  parameter int FRAME_BYTES = 34,
  localparam int IDX_W = $clog2(FRAME_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             link_ok_i,
  input  logic             in_frame_i,
  output logic             pend_o,
  output logic             send_o,
  output logic             launch_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic             pend_q, send_q;
  logic [IDX_W-1:0] idx_q;
  logic             launch, last;

  assign launch = pend_q && link_ok_i && !in_frame_i && !send_q;
  assign last   = idx_q == IDX_W'(FRAME_BYTES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      send_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      // merge: a request while pending or sending adds nothing
      pend_q <= link_ok_i && !launch && (pend_q || (req_i && !send_q));
      if (launch) begin
        send_q <= 1'b1;
        idx_q  <= '0;
      end else if (send_q) begin
        if (last) send_q <= 1'b0;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign pend_o   = pend_q;
  assign send_o   = send_q;
  assign launch_o = launch;
  assign idx_o    = idx_q;
  assign last_o   = last;
endmodule

// File: rtl/pfc_tx_gen.sv
module pfc_tx_gen
  import pfc_pkg::*;
#(
  parameter int NUM_PRIO = 8,
  parameter int QUANTA_W = 16,
  parameter int PEV_W    = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         full_duplex_i,
  input  logic                         tx_en_i,
  input  logic [47:0]                  src_addr_i,
  input  logic [PEV_W-1:0]             pev_i,
  input  logic [NUM_PRIO*QUANTA_W-1:0] quanta_i,
  input  logic [7:0]                   norm_data_i,
  input  logic                         norm_valid_i,
  input  logic                         norm_sof_i,
  input  logic                         norm_eof_i,
  output logic                         norm_gnt_o,
  output logic [7:0]                   tx_data_o,
  output logic                         tx_valid_o,
  output logic                         tx_sof_o,
  output logic                         tx_eof_o
);
  localparam int FRAME_BYTES = frame_bytes(PEV_W, NUM_PRIO, QUANTA_W);
  localparam int FRAME_BITS  = 8 * FRAME_BYTES;
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  logic [FRAME_BITS-1:0] frame_w, frame_q, frame_sh;
  logic [IDX_W-1:0]      idx_w;
  logic pend_w, send_w, launch_w, last_w, in_frame_w, link_ok;
  logic gnt;

  assign link_ok = full_duplex_i && tx_en_i;
  assign gnt     = !send_w && !launch_w;

  pfc_frame_build #(.NUM_PRIO(NUM_PRIO), .QUANTA_W(QUANTA_W), .PEV_W(PEV_W)) u_build (
    .src_addr_i (src_addr_i),
    .pev_i      (pev_i),
    .quanta_i   (quanta_i),
    .frame_o    (frame_w)
  );

  pfc_gap_track u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (norm_valid_i && gnt),
    .sof_i      (norm_sof_i),
    .eof_i      (norm_eof_i),
    .in_frame_o (in_frame_w)
  );

  pfc_tx_seq #(.FRAME_BYTES(FRAME_BYTES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .link_ok_i  (link_ok),
    .in_frame_i (in_frame_w),
    .pend_o     (pend_w),
    .send_o     (send_w),
    .launch_o   (launch_w),
    .idx_o      (idx_w),
    .last_o     (last_w)
  );

  // snapshot of all fields at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       frame_q <= '0;
    else if (launch_w) frame_q <= frame_w;
  end

  assign frame_sh = frame_q << {idx_w, 3'b000};

  always_comb begin
    tx_data_o  = '0;
    tx_valid_o = 1'b0;
    tx_sof_o   = 1'b0;
    tx_eof_o   = 1'b0;
    if (send_w) begin
      tx_data_o  = frame_sh[FRAME_BITS-1 -: 8];
      tx_valid_o = 1'b1;
      tx_sof_o   = idx_w == '0;
      tx_eof_o   = last_w;
    end else if (gnt) begin
      tx_data_o  = norm_data_i;
      tx_valid_o = norm_valid_i;
      tx_sof_o   = norm_sof_i;
      tx_eof_o   = norm_eof_i;
    end
  end

  assign norm_gnt_o = gnt;
endmodule

// File: rtl/pfc_tx_gen_chk.sv
module pfc_tx_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic full_duplex_i,
  input logic tx_en_i,
  input logic norm_valid_i,
  input logic norm_gnt_o,
  input logic tx_valid_o,
  input logic tx_sof_o,
  input logic tx_eof_o,
  input logic pend_w,
  input logic send_w,
  input logic launch_w,
  input logic in_frame_w
);
  AST_MARK_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sof_o || tx_eof_o) |-> tx_valid_o); // R4

  AST_SEND_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_w && !tx_eof_o) |=> (send_w && tx_valid_o && !tx_sof_o)); // R4

  AST_GAP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_w |-> !in_frame_w); // R6

  AST_GNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_w |-> !norm_gnt_o); // R7

  AST_EOF_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_w && tx_eof_o) |=> (!send_w && norm_gnt_o)); // R7

  AST_NO_DOUBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_w |-> !send_w); // R8

  AST_DROP_OFFLINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(full_duplex_i && tx_en_i) && !pend_w) |=> !pend_w); // R2

  AST_WITHDRAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_duplex_i && tx_en_i) |=> !pend_w); // R10

  AST_PASS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_gnt_o |-> (tx_valid_o == norm_valid_i)); // R11
endmodule

bind pfc_tx_gen pfc_tx_gen_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .full_duplex_i (full_duplex_i),
  .tx_en_i       (tx_en_i),
  .norm_valid_i  (norm_valid_i),
  .norm_gnt_o    (norm_gnt_o),
  .tx_valid_o    (tx_valid_o),
  .tx_sof_o      (tx_sof_o),
  .tx_eof_o      (tx_eof_o),
  .pend_w        (pend_w),
  .send_w        (send_w),
  .launch_w      (launch_w),
  .in_frame_w    (in_frame_w)
);

// File: tb/pfc_tx_gen_tb.sv
`timescale 1ns/1ps
module pfc_tx_gen_tb;
  localparam int FB = 34;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, fd = 1'b1, ten = 1'b1;
  logic [47:0]  sa = '0;
  logic [15:0]  pev = '0;
  logic [127:0] qt = '0;
  logic [7:0]   nd = '0;
  logic         nv = 1'b0, ns = 1'b0, ne = 1'b0;
  logic         gnt, tv, tsof, teof;
  logic [7:0]   td;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] cap_d[$];
  bit         cap_s[$], cap_e[$];
  int         cap_c[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pfc_tx_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .full_duplex_i(fd), .tx_en_i(ten),
    .src_addr_i(sa), .pev_i(pev), .quanta_i(qt),
    .norm_data_i(nd), .norm_valid_i(nv), .norm_sof_i(ns), .norm_eof_i(ne),
    .norm_gnt_o(gnt), .tx_data_o(td), .tx_valid_o(tv), .tx_sof_o(tsof), .tx_eof_o(teof)
  );

  always @(negedge clk) if (rst_n && tv) begin
    cap_d.push_back(td); cap_s.push_back(tsof); cap_e.push_back(teof); cap_c.push_back(cyc);
  end

  task automatic chk(bit ok, string r, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic clr();
    cap_d.delete(); cap_s.delete(); cap_e.delete(); cap_c.delete();
  endtask

  function automatic logic [7:0] exp_byte(int k, logic [47:0] a, logic [15:0] v, logic [127:0] q);
    logic [47:0] da = 48'h0180C2000001;
    int p;
    if (k < 6)   return da[8*(5-k) +: 8];
    if (k < 12)  return a[8*(11-k) +: 8];
    if (k == 12) return 8'h88;
    if (k == 13) return 8'h08;
    if (k == 14 || k == 15) return 8'h01;
    if (k == 16) return v[15:8];
    if (k == 17) return v[7:0];
    p = (k - 18) / 2;
    return ((k - 18) % 2 == 0) ? q[16*p+8 +: 8] : q[16*p +: 8];
  endfunction

  task automatic chk_frame(int s, logic [47:0] a, logic [15:0] v, logic [127:0] q, string r);
    int bad = 0, badf = 0, badc = 0;
    if (cap_d.size() < s + FB) begin
      chk(0, r, "frame length", cap_d.size(), s + FB);
      return;
    end
    for (int k = 0; k < FB; k++) begin
      if (cap_d[s+k] !== exp_byte(k, a, v, q)) begin
        bad++;
        $display("FAIL %s byte %0d: actual %0h expected %0h", r, k, cap_d[s+k], exp_byte(k, a, v, q));
      end
      if (cap_s[s+k] != (k == 0) || cap_e[s+k] != (k == FB-1)) badf++;
      if (k > 0 && cap_c[s+k] != cap_c[s+k-1] + 1) badc++;
    end
    n_chk++; if (bad != 0) n_bad++;
    chk(badf == 0, "R4", "marker errors", badf, 0);
    chk(badc == 0, "R4", "gap cycles", badc, 0);
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic send_norm(int len, logic [7:0] base);
    bit a;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      nv = 1'b1; nd = base + 8'(i); ns = (i == 0); ne = (i == len-1);
      forever begin
        #2; a = gnt;
        @(posedge clk);
        if (a) break;
        @(negedge clk);
      end
    end
    @(negedge clk); nv = 1'b0; ns = 1'b0; ne = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tv == 1'b0, "R1", "valid after reset", tv, 0);
    chk(gnt == 1'b1, "R1", "grant after reset", gnt, 1);
  endtask

  task automatic t_idle();
    int c;
    clr();
    sa = 48'h0A1B2C3D4E5F; pev = 16'h00A5; qt = 128'h1111_2222_3333_4444_5555_6666_7777_ABCD;
    @(negedge clk); req = 1'b1; c = cyc;
    @(negedge clk); req = 1'b0;
    repeat (45) @(negedge clk);
    chk(cap_d.size() == FB, "R3", "idle byte count", cap_d.size(), FB);
    if (cap_c.size() > 0) chk(cap_c[0] == c + 2, "R5", "start cycle", cap_c[0], c + 2);
    chk_frame(0, sa, pev, qt, "R3");
  endtask

  task automatic t_offline(bit use_fd);
    clr();
    if (use_fd) fd = 1'b0; else ten = 1'b0;
    pulse_req();
    @(negedge clk); fd = 1'b1; ten = 1'b1;
    repeat (50) @(negedge clk);
    chk(cap_d.size() == 0, "R2", use_fd ? "half duplex bytes" : "tx off bytes", cap_d.size(), 0);
  endtask

  task automatic t_merge();
    clr();
    sa = 48'h112233445566; pev = 16'h8001; qt = {8{16'h0F0F}};
    pulse_req();
    pulse_req();
    repeat (6) @(negedge clk);
    pulse_req();
    repeat (80) @(negedge clk);
    chk(cap_d.size() == FB, "R8", "merged byte count", cap_d.size(), FB);
  endtask

  task automatic t_midframe();
    clr();
    sa = 48'hC0FFEE001234; pev = 16'h00FF; qt = 128'h0001_0002_0003_0004_0005_0006_0007_0008;
    fork
      begin send_norm(10, 8'hA0); send_norm(5, 8'hB0); end
      begin repeat (4) @(negedge clk); pulse_req(); end
    join
    repeat (20) @(negedge clk);
    chk(cap_d.size() == 10 + FB + 5, "R6", "total bytes", cap_d.size(), 10 + FB + 5);
    if (cap_d.size() == 10 + FB + 5) begin
      for (int i = 0; i < 10; i++)
        chk(cap_d[i] == 8'hA0 + 8'(i), "R11", "normal byte", cap_d[i], 8'hA0 + 8'(i));
      chk(cap_s[0] && cap_e[9], "R11", "normal markers", {cap_s[0], cap_e[9]}, 2'b11);
      chk(cap_c[10] > cap_c[9], "R6", "pause after normal eof", cap_c[10], cap_c[9] + 1);
      chk_frame(10, sa, pev, qt, "R6");
      chk(cap_d[44] == 8'hB0 && cap_s[44], "R7", "held frame first byte", cap_d[44], 8'hB0);
      chk(cap_c[44] == cap_c[43] + 1, "R7", "grant return cycle", cap_c[44], cap_c[43] + 1);
      chk(cap_e[48], "R7", "held frame end", cap_e[48], 1);
    end
  endtask

  task automatic t_snapshot();
    logic [47:0] a0; logic [15:0] v0; logic [127:0] q0;
    clr();
    sa = 48'h5A5A5A5A5A5A; pev = 16'h0033; qt = {8{16'hBEEF}};
    a0 = sa; v0 = pev; q0 = qt;
    pulse_req();
    while (!tsof) @(negedge clk);
    sa = 48'hFFFFFFFFFFFF; pev = 16'hFFFF; qt = '0;
    repeat (45) @(negedge clk);
    chk_frame(0, a0, v0, q0, "R9");
  endtask

  task automatic t_cancel();
    clr();
    fork
      send_norm(10, 8'hC0);
      begin
        repeat (3) @(negedge clk); pulse_req();
        repeat (2) @(negedge clk); fd = 1'b0;
        repeat (3) @(negedge clk); fd = 1'b1;
      end
    join
    repeat (50) @(negedge clk);
    chk(cap_d.size() == 10, "R10", "bytes after withdrawal", cap_d.size(), 10);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_offline(1'b1);
    t_offline(1'b0);
    t_merge();
    t_midframe();
    t_snapshot();
    t_cancel();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule